// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

This block is the integer datapath of a small processor core. Each clock cycle it takes two 16-bit operands, an operation code, a byte/word width select and the current carry flag. It computes one of thirteen arithmetic or logical operations and produces the result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow.

It also drives a write enable for the destination register and a per-flag update mask. The surrounding core merges the new flags into its flag register under that mask. Every operation has its own flag policy. Increment and decrement keep the carry. Negate sets the carry for any nonzero operand. The logical operations clear carry and overflow. NOT changes no flag. Compare and test set flags but write nothing.

All outputs are registered, so results appear one clock after the inputs are presented. A synchronous active-high reset clears every output.

Top module: `bw_alu`

## Requirements
- R1: Outputs are registered with one cycle of latency. After a clock edge that samples `rst` high, `res_o`, `wr_o`, `flags_o` and `upd_o` are all zero. The flag bits are laid out as bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign and bit 5 overflow, and `upd_o` uses the same positions.
- R2: Opcode 0 adds. Opcode 1 adds plus `carry_i`. Opcode 2 subtracts B from A. Opcode 3 subtracts B and `carry_i` from A. Opcode 7 (compare) computes A minus B. For all five, carry is the carry out or borrow out of the top bit, overflow is the signed overflow, and `upd_o` is 6'h3F.
- R3: When `word_i` is 0, only the low 8 bits of each operand are used, `res_o[15:8]` is 0, and sign, carry and overflow are taken at bit 7. When `word_i` is 1 they are taken at bit 15.
- R4: Opcode 4 (A+1) and opcode 5 (A-1) update every flag except carry. The carry bit of `upd_o` is 0 and the carry bit of `flags_o` repeats `carry_i`.
- R5: Opcode 6 yields 0 minus A (two's complement). Carry is 1 exactly when the operand at the selected width is nonzero.
- R6: Compare (7) and test (12) drive `wr_o` low and still update flags. Every other defined opcode (0 to 11) drives `wr_o` high.
- R7: Opcodes 8 (AND), 9 (OR), 10 (XOR) and 12 (test, an AND) force carry and overflow to 0. They drive auxiliary carry to 0 with its `upd_o` bit 0, and post sign, zero and parity from the result.
- R8: Opcode 11 inverts every bit of A at the selected width and sets `upd_o` to 0.
- R9: Parity is 1 when the low 8 bits of the result hold an even number of ones. Auxiliary carry is the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions. Zero is 1 when the result at the selected width is 0.
- R10: Opcodes 13 to 15 are unused. They give a result of 0, `wr_o` 0 and `upd_o` 0.
- R11: Any flag whose `upd_o` bit is 0 reads 0 in `flags_o`, except carry, which repeats `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opa_i | input | 16 | Destination operand A |
| opb_i | input | 16 | Source operand B |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 16 | Registered result |
| wr_o | output | 1 | Destination write enable |
| flags_o | output | 6 | New status flags |
| upd_o | output | 6 | Per-flag update mask |

## Verification
The assertions assume that every input is a known value on every clock edge after reset, including the upper operand byte in byte mode and the unused opcodes. They do not assume that the operands fit the selected width or that the opcode is defined. The stimulus drives every opcode from 0 to 15, both widths, random upper bytes and both carry values. It also includes directed operands that hit the carry, borrow, overflow and zero boundaries of both widths.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_CMP  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_TEST = 4'd12
  } alu_op_e;

  // flag vector bit positions
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;
  localparam int FL_N = 6;

  // bit whose carry-in forms the auxiliary carry
  localparam int NIB_W = 4;

endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,   // carry (add) or borrow (sub) into bit 0
  input  logic              sub_i,
  input  logic              word_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              of_o
);
  import bw_alu_pkg::*;

  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] wmask, xm, ym;
  logic [DATA_W:0]   s;
  logic              c0, c_nib, c_out, c_into;

  always_comb begin
    wmask = word_i ? {DATA_W{1'b1}} : BYTE_MASK;
    xm    = x_i & wmask;
    ym    = (sub_i ? ~y_i : y_i) & wmask;
    c0    = sub_i ? ~cin_i : cin_i;
    s     = {1'b0, xm} + {1'b0, ym} + (DATA_W+1)'(c0);
    c_nib = xm[NIB_W] ^ ym[NIB_W] ^ s[NIB_W];
    if (word_i) begin
      c_out  = s[DATA_W];
      c_into = xm[DATA_W-1] ^ ym[DATA_W-1] ^ s[DATA_W-1];
    end else begin
      c_out  = s[BYTE_W];
      c_into = xm[BYTE_W-1] ^ ym[BYTE_W-1] ^ s[BYTE_W-1];
    end
    sum_o = s[DATA_W-1:0] & wmask;
    cf_o  = c_out ^ sub_i;   // borrow is the inverted carry
    af_o  = c_nib ^ sub_i;
    of_o  = c_out ^ c_into;
  end

endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic #(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] r_o
);
  import bw_alu_pkg::*;

  always_comb begin
    case (op_i)
      OP_AND, OP_TEST: r_o = a_i & b_i;
      OP_OR:           r_o = a_i | b_i;
      OP_XOR:          r_o = a_i ^ b_i;
      OP_NOT:          r_o = ~a_i;
      default:         r_o = '0;
    endcase
  end

endmodule

// File: rtl/bw_alu_policy.sv
module bw_alu_policy #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              cf_i,
  input  logic              af_i,
  input  logic              of_i,
  input  logic [DATA_W-1:0] lres_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [FL_N-1:0]   flags_o,
  output logic [FL_N-1:0]   upd_o
);
  import bw_alu_pkg::*;

  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [FL_N-1:0]   ALL_FL    = {FL_N{1'b1}};

  logic              is_arith, is_logic, is_not;
  logic [DATA_W-1:0] wmask;
  logic [FL_N-1:0]   cand;

  always_comb begin
    is_arith = (op_i <= OP_CMP);
    is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_TEST);
    is_not   = (op_i == OP_NOT);
    wmask    = word_i ? {DATA_W{1'b1}} : BYTE_MASK;

    if (is_arith)                 res_o = sum_i;
    else if (is_logic || is_not)  res_o = lres_i & wmask;
    else                          res_o = '0;

    wr_o = (is_arith && op_i != OP_CMP) || (is_logic && op_i != OP_TEST) || is_not;

    cand        = '0;
    cand[FL_C]  = is_arith ? cf_i : 1'b0;
    cand[FL_A]  = is_arith ? af_i : 1'b0;
    cand[FL_O]  = is_arith ? of_i : 1'b0;
    cand[FL_S]  = word_i ? res_o[DATA_W-1] : res_o[BYTE_W-1];
    cand[FL_Z]  = ~|res_o;
    cand[FL_P]  = ~^res_o[BYTE_W-1:0];

    if (is_arith) begin
      upd_o = ALL_FL;
      if (op_i == OP_INC || op_i == OP_DEC) upd_o[FL_C] = 1'b0;
    end else if (is_logic) begin
      upd_o       = ALL_FL;
      upd_o[FL_A] = 1'b0;
    end else begin
      upd_o = '0;
    end

    flags_o = cand & upd_o;
    if (!upd_o[FL_C]) flags_o[FL_C] = carry_i;
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output logic [5:0]        flags_o,
  output logic [5:0]        upd_o
);
  import bw_alu_pkg::*;

  logic [DATA_W-1:0] x, y, sum, lres, res_n;
  logic              cin, sub, cf, af, of, wr_n;
  logic [FL_N-1:0]   flags_n, upd_n;

  // operand steering for the shared adder
  always_comb begin
    x   = opa_i;
    y   = opb_i;
    cin = 1'b0;
    sub = 1'b0;
    case (op_i)
      OP_ADC:         cin = carry_i;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; cin = carry_i; end
      OP_INC:         y = DATA_W'(1);
      OP_DEC: begin y = DATA_W'(1); sub = 1'b1; end
      OP_NEG: begin x = '0; y = opa_i; sub = 1'b1; end
      default: ;
    endcase
  end

  bw_alu_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_addsub (
    .x_i(x), .y_i(y), .cin_i(cin), .sub_i(sub), .word_i(word_i),
    .sum_o(sum), .cf_o(cf), .af_o(af), .of_o(of)
  );

  bw_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_i), .a_i(opa_i), .b_i(opb_i), .r_o(lres)
  );

  bw_alu_policy #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_policy (
    .op_i(op_i), .word_i(word_i), .carry_i(carry_i),
    .sum_i(sum), .cf_i(cf), .af_i(af), .of_i(of), .lres_i(lres),
    .res_o(res_n), .wr_o(wr_n), .flags_o(flags_n), .upd_o(upd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      wr_o    <= 1'b0;
      flags_o <= '0;
      upd_o   <= '0;
    end else begin
      res_o   <= res_n;
      wr_o    <= wr_n;
      flags_o <= flags_n;
      upd_o   <= upd_n;
    end
  end

endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic              word_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_o,
  input logic [5:0]        flags_o,
  input logic [5:0]        upd_o
);
  import bw_alu_pkg::*;

  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !word_i |=> res_o[DATA_W-1:BYTE_W] == '0);

  a_r4_carry_kept: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INC || op_i == OP_DEC) |=> (!upd_o[FL_C] && flags_o[FL_C] == $past(carry_i)));

  a_r5_neg_carry: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NEG) |=> flags_o[FL_C] == ($past(word_i) ? ($past(opa_i) != '0)
                                                         : ($past(opa_i[BYTE_W-1:0]) != '0)));

  a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP || op_i == OP_TEST) |=> (!wr_o && upd_o != '0));

  a_r7_logic_clear: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TEST)
      |=> (!flags_o[FL_C] && !flags_o[FL_O] && !flags_o[FL_A] && !upd_o[FL_A]));

  a_r8_not_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOT) |=> (upd_o == '0 && wr_o));

  a_r9_zero_match: assert property (@(posedge clk) disable iff (rst)
    upd_o[FL_Z] |-> (flags_o[FL_Z] == (res_o == '0)));

  a_r10_unused: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_TEST) |=> (!wr_o && upd_o == '0 && res_o == '0));

  a_r11_idle_flags: assert property (@(posedge clk) disable iff (rst)
    (upd_o == '0) |-> (flags_o[FL_N-1:1] == '0));

endmodule

bind bw_alu bw_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .word_i(word_i), .opa_i(opa_i),
  .opb_i(opb_i), .carry_i(carry_i), .res_o(res_o), .wr_o(wr_o),
  .flags_o(flags_o), .upd_o(upd_o)
);

// File: tb/bw_alu_tb.sv
`timescale 1ns/1ps
module bw_alu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic        word = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        cin = 1'b0;
  logic [15:0] res;
  logic        wr;
  logic [5:0]  flags, upd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bw_alu u_dut (
    .clk(clk), .rst(rst), .op_i(op), .word_i(word), .opa_i(opa), .opb_i(opb),
    .carry_i(cin), .res_o(res), .wr_o(wr), .flags_o(flags), .upd_o(upd)
  );

  // expected {res, wr, flags, upd}; flags: 0 C, 1 P, 2 A, 3 Z, 4 S, 5 O
  function automatic logic [28:0] model(input logic [3:0] o, input logic w16,
                                        input logic [15:0] ai, input logic [15:0] bi,
                                        input logic ci);
    int w, m, a, b, x, y, c, r, sx, sy, sr;
    bit arith, sub, lg, cf, af, of, wr_e;
    logic [15:0] rr;
    logic [5:0]  f, u;
    w = w16 ? 16 : 8;
    m = (1 << w) - 1;
    a = int'(ai) & m;
    b = int'(bi) & m;
    x = a; y = b; c = 0; sub = 0; arith = (o <= 4'd7);
    lg = (o == 4'd8) || (o == 4'd9) || (o == 4'd10) || (o == 4'd12);
    cf = 0; af = 0; of = 0; r = 0;
    case (o)
      4'd1: c = ci;
      4'd2, 4'd7: sub = 1;
      4'd3: begin sub = 1; c = ci; end
      4'd4: y = 1;
      4'd5: begin y = 1; sub = 1; end
      4'd6: begin x = 0; y = a; sub = 1; end
      4'd8, 4'd12: r = a & b;
      4'd9: r = a | b;
      4'd10: r = a ^ b;
      4'd11: r = ~a & m;
      default: r = 0;
    endcase
    if (arith) begin
      sx = (x >> (w-1)) & 1;
      sy = (y >> (w-1)) & 1;
      if (sub) begin
        r  = x - y - c;
        cf = (r < 0);
        af = (((x & 15) - (y & 15) - c) < 0);
        r  = r & m;
        sr = (r >> (w-1)) & 1;
        of = (sx != sy) && (sr != sx);
      end else begin
        r  = x + y + c;
        cf = (r > m);
        af = (((x & 15) + (y & 15) + c) > 15);
        r  = r & m;
        sr = (r >> (w-1)) & 1;
        of = (sx == sy) && (sr != sx);
      end
    end
    rr = 16'(r);
    wr_e = (o <= 4'd11) && (o != 4'd7);
    if (arith) u = (o == 4'd4 || o == 4'd5) ? 6'h3E : 6'h3F;
    else if (lg) u = 6'h3B;
    else u = 6'h00;
    f = '0;
    f[0] = cf;
    f[1] = ~^rr[7:0];
    f[2] = af;
    f[3] = (rr == 16'h0);
    f[4] = w16 ? rr[15] : rr[7];
    f[5] = of;
    f = f & u;
    if (!u[0]) f[0] = ci;
    return {rr, wr_e, f, u};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7, 4'd12: return "R6";
      4'd8, 4'd9, 4'd10: return "R7";
      4'd11: return "R8";
      default: return "R10";
    endcase
  endfunction

  // called at a falling edge: drive, then compare one falling edge later
  task automatic run(input logic [3:0] o, input logic w16, input logic [15:0] a,
                     input logic [15:0] b, input logic c);
    logic [28:0] exp_v, got;
    op = o; word = w16; opa = a; opb = b; cin = c;
    exp_v = model(o, w16, a, b, c);
    @(negedge clk);
    got = {res, wr, flags, upd};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s%s op=%0d word=%0d a=%h b=%h c=%0d got res=%h wr=%0d fl=%b upd=%b exp res=%h wr=%0d fl=%b upd=%b",
               tag(o), w16 ? "" : "/R3", o, w16, a, b, c, got[28:13], got[12], got[11:6], got[5:0],
               exp_v[28:13], exp_v[12], exp_v[11:6], exp_v[5:0]);
    end
  endtask

  task automatic check_reset();
    n_chk++;
    if ({res, wr, flags, upd} !== 29'h0) begin
      n_bad++;
      $display("FAIL R1 reset outputs got %h expected 0", {res, wr, flags, upd});
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(negedge clk);
    check_reset();                                  // R1 after reset
    op = 4'd0; word = 1'b1; opa = 16'hFFFF; opb = 16'h0001; cin = 1'b1;
    @(negedge clk);
    check_reset();                                  // R1 reset holds over live inputs
    rst = 1'b0;

    // R2 / R3 / R9: byte carry out, zero, aux carry
    run(4'd0, 1'b0, 16'hAAFF, 16'h5501, 1'b0);
    // R2 word signed overflow
    run(4'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0);
    // R2 add with carry folds carry_i
    run(4'd1, 1'b1, 16'hFFFE, 16'h0001, 1'b1);
    // R2 subtract with borrow underflows from zero
    run(4'd3, 1'b0, 16'h0000, 16'h0000, 1'b1);
    run(4'd2, 1'b1, 16'h8000, 16'h0001, 1'b0);
    // R4 increment wraps, carry echoes carry_i both ways
    run(4'd4, 1'b1, 16'hFFFF, 16'h0000, 1'b0);
    run(4'd4, 1'b1, 16'hFFFF, 16'h0000, 1'b1);
    run(4'd5, 1'b0, 16'h1280, 16'h0000, 1'b1);
    // R5 negate zero and most negative byte
    run(4'd6, 1'b1, 16'h0000, 16'h0000, 1'b1);
    run(4'd6, 1'b0, 16'hFF80, 16'h0000, 1'b0);
    run(4'd6, 1'b0, 16'h1200, 16'h0000, 1'b0);
    // R6 compare equal, test with overlapping bits
    run(4'd7, 1'b1, 16'h1234, 16'h1234, 1'b0);
    run(4'd12, 1'b1, 16'hF0F0, 16'h8001, 1'b1);
    // R7 / R9 logic and parity
    run(4'd8, 1'b1, 16'hFFFF, 16'h00FF, 1'b1);
    run(4'd10, 1'b0, 16'h0003, 16'h0001, 1'b0);
    run(4'd9, 1'b1, 16'h0000, 16'h0000, 1'b1);
    // R8 / R11 NOT leaves flags alone, carry echoed
    run(4'd11, 1'b0, 16'h5A5A, 16'h0000, 1'b1);
    run(4'd11, 1'b1, 16'h0000, 16'h0000, 1'b0);
    // R10 unused codes
    run(4'd13, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    run(4'd15, 1'b0, 16'h1234, 16'h4321, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if ($urandom_range(0, 7) == 0) ra = ($urandom_range(0, 1) != 0) ? 16'h0000 : 16'hFFFF;
      if ($urandom_range(0, 7) == 0) rb = 16'h0080 << $urandom_range(0, 8);
      run(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), ra, rb, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule